// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block derives the serial clock of an I2C master from a faster system clock. A 16-bit divider word holds two independent byte-wide counts, one for the high half of the serial clock and one for the low half. Each half lasts its programmed count plus two system cycles. The block is therefore not a symmetric divide-by-N. The serial frequency is the system frequency divided by the sum of both counts plus four.

A bit-level controller sits next to this block and needs to know when the serial clock changes. It gets a one-cycle strobe on every rising edge and on every falling edge of the serial clock. The block samples the divider only when a phase begins, so software may rewrite it at any time without shortening or stretching the phase already running. While the enable input is low, the line is released high and all timing state is held cleared. When the enable returns, the block always starts with a low phase.

Top module: `scl_rate_gen`

## Requirements
- R1: While `rst` is high, `scl_o` is 1 and `rise_stb` and `fall_stb` are 0.
- R2: One cycle after `en` is first sampled high, `scl_o` is 0 and `fall_stb` is 1, so the first phase is always a low phase.
- R3: A low phase lasts `div_cfg[7:0]` + 2 system cycles.
- R4: A high phase lasts `div_cfg[15:8]` + 2 system cycles.
- R5: `div_cfg` = 16'hCFCF gives 209 cycles high and 209 cycles low, which is a period of 418 cycles.
- R6: `div_cfg` = 16'h283C gives 42 cycles high and 62 cycles low, which is a period of 104 cycles.
- R7: `rise_stb` is high for exactly the one cycle in which `scl_o` has just gone from 0 to 1 while enabled.
- R8: `fall_stb` is high for exactly the one cycle in which `scl_o` has just gone from 1 to 0.
- R9: `div_cfg` is sampled only when a phase starts, so a change during a phase leaves that phase's length unchanged.
- R10: One cycle after `en` is sampled low, `scl_o` is 1 and neither strobe is set. A later enable restarts with a low phase, as in R2.
- R11: `div_cfg` = 16'h0000 gives the shortest clock, 2 cycles high and 2 cycles low.
- R12: The two strobes are never high together, and no strobe is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run the serial clock; when low, the line is released high |
| div_cfg | input | 16 | High-phase count in [15:8], low-phase count in [7:0] |
| scl_o | output | 1 | Serial clock drive level (1 = released high) |
| rise_stb | output | 1 | One-cycle pulse on a low-to-high serial clock edge |
| fall_stb | output | 1 | One-cycle pulse on a high-to-low serial clock edge |

## Verification
All three outputs are registered, so every response to `en` and to a phase boundary shows one system clock after the edge that sampled the cause. A change of `div_cfg` shows only at the next phase start, which may be up to 257 cycles later. The bench drives inputs on the falling clock edge. Its behavioural model advances on the rising edge using the same sampled inputs, and the outputs are compared on the next falling edge. Phase lengths are measured from the strobes: a low phase is counted from a fall strobe to the next rise strobe, and a high phase from the rise strobe to the next fall strobe. For R9, the divider is rewritten two cycles into a low phase, and the bench expects the old low count followed by the new high count.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Phase of the serial clock; IDLE means disabled with the line released.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

endpackage

// File: rtl/scl_len_sel.sv
// Picks the count for the phase about to start and adds the fixed offset.
// The loaded value is the number of cycles still left after the first one.
module scl_len_sel
  import scl_gen_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int OFFSET = 2,
  parameter int LD_W   = 9
) (
  input  scl_phase_e         phase_nxt,
  input  logic [2*CNT_W-1:0] div_cfg,
  output logic [LD_W-1:0]    load_val
);

  logic [CNT_W-1:0] field;

  always_comb begin
    if (phase_nxt == PH_HIGH) field = div_cfg[2*CNT_W-1:CNT_W];
    else                      field = div_cfg[CNT_W-1:0];
    load_val = LD_W'(field) + LD_W'(OFFSET - 1);
  end

endmodule

// File: rtl/scl_phase_cnt.sv
// Down-counter for the cycles left in the current phase.
module scl_phase_cnt #(
  parameter int LD_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            load,
  input  logic [LD_W-1:0] load_val,
  output logic            done
);

  logic [LD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/scl_phase_seq.sv
// Phase sequencer: IDLE -> LOW -> HIGH -> LOW ... while enabled.
module scl_phase_seq
  import scl_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       done,
  output scl_phase_e phase_q,
  output scl_phase_e phase_nxt,
  output logic       advance
);

  always_comb begin
    advance   = en && ((phase_q == PH_IDLE) || done);
    phase_nxt = phase_q;
    if (!en)
      phase_nxt = PH_IDLE;
    else if (advance)
      phase_nxt = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_nxt;
  end

endmodule

// File: rtl/scl_edge_out.sv
// Registered line level and edge strobes.
module scl_edge_out
  import scl_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       advance,
  input  scl_phase_e phase_nxt,
  output logic       scl_o,
  output logic       rise_stb,
  output logic       fall_stb
);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_o    <= 1'b1;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      scl_o    <= (phase_nxt != PH_LOW);
      rise_stb <= advance && (phase_nxt == PH_HIGH);
      fall_stb <= advance && (phase_nxt == PH_LOW);
    end
  end

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int OFFSET = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [2*CNT_W-1:0] div_cfg,
  output logic               scl_o,
  output logic               rise_stb,
  output logic               fall_stb
);

  localparam int LD_W = $clog2((1 << CNT_W) + OFFSET);

  scl_phase_e      phase_q;
  scl_phase_e      phase_nxt;
  logic            advance;
  logic            done;
  logic [LD_W-1:0] load_val;

  scl_phase_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .done      (done),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .advance   (advance)
  );

  scl_len_sel #(
    .CNT_W  (CNT_W),
    .OFFSET (OFFSET),
    .LD_W   (LD_W)
  ) u_len (
    .phase_nxt (phase_nxt),
    .div_cfg   (div_cfg),
    .load_val  (load_val)
  );

  scl_phase_cnt #(
    .LD_W (LD_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (!en),
    .load     (advance),
    .load_val (load_val),
    .done     (done)
  );

  scl_edge_out u_out (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .phase_nxt (phase_nxt),
    .scl_o     (scl_o),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb)
  );

endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic scl_o,
  input logic rise_stb,
  input logic fall_stb
);

  AST_RISE_ON_LIFT: assert property (@(posedge clk) disable iff (rst)
    ($rose(scl_o) && $past(en)) |-> rise_stb); // R7

  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> (scl_o && $past(!scl_o))); // R7

  AST_FALL_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_o) |-> fall_stb); // R8

  AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> (!scl_o && $past(scl_o))); // R8

  AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_o && !rise_stb && !fall_stb)); // R10

  AST_ENABLE_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    (en && $past(!en)) |=> (!scl_o && fall_stb)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_stb && fall_stb)); // R12

  AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (rst)
    (rise_stb || fall_stb) |=> !(rise_stb || fall_stb)); // R12

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (scl_o && !rise_stb && !fall_stb)); // R1

endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .scl_o    (scl_o),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb)
);

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] div_cfg = 16'h0000;
  logic        scl_o, rise_stb, fall_stb;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done_run = 0;

  // Behavioural reference: phase kind, cycles spent, cycles due.
  int m_ph  = 0;  // 0 off, 1 low, 2 high
  int m_age = 0;
  int m_len = 0;
  bit m_scl = 1, m_r = 0, m_f = 0;

  scl_rate_gen dut (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .div_cfg  (div_cfg),
    .scl_o    (scl_o),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    m_r = 0;
    m_f = 0;
    if (rst || !en) begin
      m_ph = 0; m_age = 0; m_scl = 1;
    end else if (m_ph == 0 || m_age == m_len) begin
      if (m_ph == 1) begin
        m_ph = 2; m_len = int'(div_cfg[15:8]) + 2; m_scl = 1; m_r = 1;
      end else begin
        m_ph = 1; m_len = int'(div_cfg[7:0]) + 2; m_scl = 0; m_f = 1;
      end
      m_age = 1;
    end else begin
      m_age++;
    end
  end

  // Cycle-by-cycle comparison against the model (R3, R4, R7, R8).
  always @(negedge clk) begin
    if (!done_run) begin
      chk(scl_o == m_scl, "R3/R4 scl_o", scl_o, m_scl);
      chk(rise_stb == m_r, "R7 rise_stb", rise_stb, m_r);
      chk(fall_stb == m_f, "R8 fall_stb", fall_stb, m_f);
    end
  end

  // Measures one low phase then one high phase, from the strobes.
  task automatic measure(input int exp_lo, input int exp_hi, input string req);
    int lo, hi;
    @(negedge clk);
    while (!fall_stb) @(negedge clk);
    lo = 1;
    @(negedge clk);
    while (!rise_stb) begin lo++; @(negedge clk); end
    hi = 1;
    @(negedge clk);
    while (!fall_stb) begin hi++; @(negedge clk); end
    chk(lo == exp_lo, {req, " low length"}, lo, exp_lo);
    chk(hi == exp_hi, {req, " high length"}, hi, exp_hi);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_o && !rise_stb && !fall_stb, "R1 reset idle", {scl_o, rise_stb, fall_stb}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_o == 1'b1, "R1 held before enable", scl_o, 1);

    // R2: enable starts with a low phase
    div_cfg = 16'h283C;
    en = 1'b1;
    @(negedge clk);
    chk(!scl_o && fall_stb, "R2 first phase low", {scl_o, fall_stb}, 2'b01);

    // R6 (also R3, R4)
    measure(62, 42, "R6");
    // R5
    div_cfg = 16'hCFCF;
    measure(209, 209, "R5");
    // R11 shortest clock
    div_cfg = 16'h0000;
    measure(2, 2, "R11");
    // R3/R4 asymmetric pair
    div_cfg = 16'h0713;
    measure(21, 9, "R3/R4");

    // R9: divider rewritten two cycles into a low phase
    div_cfg = 16'h0305;
    @(negedge clk);
    while (!fall_stb) @(negedge clk);
    while (!fall_stb) @(negedge clk);
    begin
      int lo, hi;
      lo = 1;
      @(negedge clk); lo++;
      div_cfg = 16'h0A0A;
      @(negedge clk);
      while (!rise_stb) begin lo++; @(negedge clk); end
      hi = 1;
      @(negedge clk);
      while (!fall_stb) begin hi++; @(negedge clk); end
      chk(lo == 7, "R9 running low phase kept", lo, 7);
      chk(hi == 12, "R9 next phase uses new count", hi, 12);
    end

    // R10: disable in the middle of a low phase
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_o && !rise_stb && !fall_stb, "R10 disable releases", {scl_o, rise_stb, fall_stb}, 3'b100);
    repeat (5) @(negedge clk);
    chk(scl_o == 1'b1, "R10 stays high", scl_o, 1);
    en = 1'b1;
    @(negedge clk);
    chk(!scl_o && fall_stb, "R10 restart low", {scl_o, fall_stb}, 2'b01);
    measure(12, 12, "R10");

    done_run = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // R12 is covered by the strobe comparison; the watchdog ends a hung run.
  initial begin
    wait (cycles > 150000);
    if (!done_run) begin
      done_run = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule